// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit

This block computes integer products and quotients over many clock cycles. It uses one adder/subtractor one word wide and one double-width shift register for both jobs. A caller raises a start strobe with an operation code and two word-wide operands. The unit then runs one iteration per clock and pulses a completion flag. A multiply leaves the full double-width product split over a high and a low result word. A divide leaves the remainder in the high word and the quotient in the low word.

Multiply is shift-and-add. The multiplier sits in the lower half of the register and is consumed from its least significant end. Divide is restoring shift-and-subtract. The dividend is shifted in from the lower half, and quotient bits fill the lower half from the right. A final right shift of the upper half yields the remainder. Signed operations run on operand magnitudes, and the signs are applied once the iterations finish. There is no trap or overflow flag. Software can inspect the high word itself.

Top module: `seq_muldiv`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy_o`, `done_o`, `hi_o` and `lo_o` are all zero.
- R2: A start sampled on a rising edge while `busy_o` is low is accepted. `busy_o` is then high for WIDTH+1 cycles. `done_o` is high for exactly the one cycle that follows, with `busy_o` low. Every operation, divide by zero included, takes this same count.
- R3: `hi_o` and `lo_o` keep their value except on the edge that raises `done_o`.
- R4: A start raised while `busy_o` is high is ignored. The operation in progress completes with its own operands, and any later change of the operand or op inputs has no effect on it.
- R5: Op code 2'b01 multiplies the operands as unsigned values. {hi_o, lo_o} holds the full 2·WIDTH-bit product.
- R6: Op code 2'b00 multiplies the operands as two's-complement values. {hi_o, lo_o} holds the signed 2·WIDTH-bit product, including for two most-negative operands.
- R7: Op code 2'b11 divides `opa_i` by `opb_i` as unsigned values. `lo_o` holds the quotient and `hi_o` holds the remainder, including for divisors with the top bit set.
- R8: Op code 2'b10 divides as two's-complement values. The quotient truncates toward zero, and the remainder takes the dividend's sign, so dividend = quotient·divisor + remainder. The most negative value divided by −1 gives `lo_o` = most negative value and `hi_o` = 0.
- R9: A divisor of zero gives `hi_o` equal to the dividend. For unsigned divide `lo_o` is all ones. For signed divide `lo_o` is all ones when the dividend is non-negative and 1 when it is negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request |
| op_i | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa_i | input | WIDTH | Multiplier or dividend |
| opb_i | input | WIDTH | Multiplicand or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | WIDTH | Upper product half or remainder |
| lo_o | output | WIDTH | Lower product half or quotient |

## Verification
The bench drives the most negative operand into both signed paths. A design that took its magnitude in too few bits would return a wrong product, or a wrong quotient for the most-negative-by-minus-one division. Unsigned divisors with the top bit set probe the extra bit above the upper half of the register; a design that dropped it would produce garbage quotients. Divide by zero, negative dividends and negative divisors check the sign handling: a missing remainder-sign fix would break the identity dividend = quotient·divisor + remainder. Start pulses arrive mid-run and in the last busy cycle. A design that re-sampled its operands would finish with the intruder's result or at the wrong time.

// File: rtl/md_pkg.sv
`timescale 1ns/1ps
package md_pkg;

    typedef enum logic [1:0] {
        OP_MUL_S = 2'b00,
        OP_MUL_U = 2'b01,
        OP_DIV_S = 2'b10,
        OP_DIV_U = 2'b11
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } md_state_e;

    // Per-operation control captured at start
    typedef struct packed {
        logic is_div;    // divide path selected
        logic neg_main;  // negate product / quotient
        logic neg_aux;   // negate remainder
    } md_ctl_t;

    function automatic logic op_is_div(md_op_e op);
        return (op == OP_DIV_S) || (op == OP_DIV_U);
    endfunction

    function automatic logic op_is_signed(md_op_e op);
        return (op == OP_MUL_S) || (op == OP_DIV_S);
    endfunction

endpackage

// File: rtl/md_sign_prep.sv
`timescale 1ns/1ps
module md_sign_prep
    import md_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  md_op_e             op_i,
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    output logic [WIDTH-1:0]   mag_a_o,
    output logic [WIDTH-1:0]   mag_b_o,
    output md_ctl_t            ctl_o
);
    logic sgn, neg_a, neg_b;

    assign sgn   = op_is_signed(op_i);
    assign neg_a = sgn & a_i[WIDTH-1];
    assign neg_b = sgn & b_i[WIDTH-1];

    // Magnitude: the most negative value maps onto its unsigned twin
    assign mag_a_o = neg_a ? (~a_i + WIDTH'(1)) : a_i;
    assign mag_b_o = neg_b ? (~b_i + WIDTH'(1)) : b_i;

    always_comb begin
        ctl_o.is_div   = op_is_div(op_i);
        ctl_o.neg_main = neg_a ^ neg_b;
        ctl_o.neg_aux  = neg_a;
    end
endmodule

// File: rtl/md_shift_core.sv
`timescale 1ns/1ps
module md_shift_core #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic               step_i,
    input  logic               busy_i,
    input  logic               is_div_i,
    input  logic [WIDTH-1:0]   opa_i,
    input  logic [WIDTH-1:0]   opb_i,
    output logic [WIDTH-1:0]   raw_hi_o,
    output logic [WIDTH-1:0]   raw_lo_o
);
    localparam int SW = WIDTH + 2;

    logic               carry_q;   // bit shifted out above the upper half
    logic [WIDTH-1:0]   hi_q, lo_q, opnd_q;
    logic               is_div_q;

    logic [WIDTH:0]     acc_a;
    logic [SW-1:0]      opnd_x, res;
    logic               fits;
    logic [WIDTH-1:0]   kept;

    // Shared adder/subtractor
    assign acc_a  = is_div_q ? {carry_q, hi_q} : {1'b0, hi_q};
    assign opnd_x = {2'b00, opnd_q};
    assign res    = {1'b0, acc_a} + (is_div_q ? ~opnd_x : opnd_x)
                  + {{(SW-1){1'b0}}, is_div_q};
    assign fits   = ~res[SW-1];
    assign kept   = fits ? res[WIDTH-1:0] : hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q  <= 1'b0;
            hi_q     <= '0;
            lo_q     <= '0;
            opnd_q   <= '0;
            is_div_q <= 1'b0;
        end else if (load_i) begin
            opnd_q   <= opb_i;
            is_div_q <= is_div_i;
            if (is_div_i)
                {carry_q, hi_q, lo_q} <= {{WIDTH{1'b0}}, opa_i, 1'b0};
            else
                {carry_q, hi_q, lo_q} <= {1'b0, {WIDTH{1'b0}}, opa_i};
        end else if (step_i) begin
            if (is_div_q) begin
                carry_q <= kept[WIDTH-1];
                hi_q    <= {kept[WIDTH-2:0], lo_q[WIDTH-1]};
                lo_q    <= {lo_q[WIDTH-2:0], fits};
            end else begin
                carry_q <= 1'b0;
                hi_q    <= lo_q[0] ? res[WIDTH:1] : {1'b0, hi_q[WIDTH-1:1]};
                lo_q    <= {(lo_q[0] ? res[0] : hi_q[0]), lo_q[WIDTH-1:1]};
            end
        end
    end

    // Divide correction: upper half shifted back by one holds the remainder
    assign raw_hi_o = is_div_q ? {carry_q, hi_q[WIDTH-1:1]} : hi_q;
    assign raw_lo_o = lo_q;

    AST_OPND_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> $stable(opnd_q) && $stable(is_div_q)); // R4
endmodule

// File: rtl/md_sign_fix.sv
`timescale 1ns/1ps
module md_sign_fix
    import md_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  md_ctl_t            ctl_i,
    input  logic [WIDTH-1:0]   raw_hi_i,
    input  logic [WIDTH-1:0]   raw_lo_i,
    output logic [WIDTH-1:0]   hi_o,
    output logic [WIDTH-1:0]   lo_o
);
    localparam int DW = 2 * WIDTH;

    logic [DW-1:0]    prod, prod_n;
    logic [WIDTH-1:0] quo_n, rem_n;

    assign prod   = {raw_hi_i, raw_lo_i};
    assign prod_n = ~prod + DW'(1);
    assign quo_n  = ~raw_lo_i + WIDTH'(1);
    assign rem_n  = ~raw_hi_i + WIDTH'(1);

    always_comb begin
        if (ctl_i.is_div) begin
            lo_o = ctl_i.neg_main ? quo_n : raw_lo_i;
            hi_o = ctl_i.neg_aux  ? rem_n : raw_hi_i;
        end else begin
            {hi_o, lo_o} = ctl_i.neg_main ? prod_n : prod;
        end
    end
endmodule

// File: rtl/seq_muldiv.sv
`timescale 1ns/1ps
module seq_muldiv
    import md_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [1:0]         op_i,
    input  logic [WIDTH-1:0]   opa_i,
    input  logic [WIDTH-1:0]   opb_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [WIDTH-1:0]   hi_o,
    output logic [WIDTH-1:0]   lo_o
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    md_state_e          state_q;
    logic [CW-1:0]      cnt_q;
    md_ctl_t            ctl_q, ctl_in;
    logic [WIDTH-1:0]   mag_a, mag_b, raw_hi, raw_lo, fix_hi, fix_lo;
    logic               accept;

    assign busy_o = (state_q != ST_IDLE);
    assign accept = start_i && !busy_o;

    md_sign_prep #(.WIDTH(WIDTH)) u_prep (
        .op_i    (md_op_e'(op_i)),
        .a_i     (opa_i),
        .b_i     (opb_i),
        .mag_a_o (mag_a),
        .mag_b_o (mag_b),
        .ctl_o   (ctl_in)
    );

    md_shift_core #(.WIDTH(WIDTH)) u_core (
        .clk      (clk),
        .rst      (rst),
        .load_i   (accept),
        .step_i   (state_q == ST_RUN),
        .busy_i   (busy_o),
        .is_div_i (ctl_in.is_div),
        .opa_i    (mag_a),
        .opb_i    (mag_b),
        .raw_hi_o (raw_hi),
        .raw_lo_o (raw_lo)
    );

    md_sign_fix #(.WIDTH(WIDTH)) u_fix (
        .ctl_i    (ctl_q),
        .raw_hi_i (raw_hi),
        .raw_lo_i (raw_lo),
        .hi_o     (fix_hi),
        .lo_o     (fix_lo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ctl_q   <= '0;
            done_o  <= 1'b0;
            hi_o    <= '0;
            lo_o    <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_RUN;
                    cnt_q   <= '0;
                    ctl_q   <= ctl_in;
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (cnt_q == CW'(WIDTH - 1))
                        state_q <= ST_FIN;
                end
                ST_FIN: begin
                    hi_o    <= fix_hi;
                    lo_o    <= fix_lo;
                    done_o  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R2
    AST_FIN_TO_DONE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FIN) |=> done_o); // R2
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(hi_o) && $stable(lo_o)); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(ctl_q)); // R4
endmodule

// File: tb/test_seq_muldiv.sv
`timescale 1ns/1ps
module test_seq_muldiv;
    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [1:0]     op = 2'b00;
    logic [W-1:0]   a = '0, b = '0;
    logic           busy, done;
    logic [W-1:0]   hi, lo;

    always #2.5 clk = ~clk;

    seq_muldiv #(.WIDTH(W)) i_seq_muldiv (
        .clk(clk), .rst(rst), .start_i(start), .op_i(op),
        .opa_i(a), .opb_i(b), .busy_o(busy), .done_o(done),
        .hi_o(hi), .lo_o(lo)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;

    // Behavioural reference state
    int             m_left = 0;
    logic           m_done = 1'b0;
    logic [W-1:0]   m_hi = '0, m_lo = '0, p_hi = '0, p_lo = '0;
    string          cur_tag = "R1", p_tag = "R1", r_tag = "R1";

    function automatic void ref_calc(input logic [1:0] o, input logic [W-1:0] x, y,
                                     output logic [W-1:0] rh, output logic [W-1:0] rl);
        longint sx, sy, q, r;
        logic [2*W-1:0] p;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        case (o)
            2'b00: begin p = 64'(sx * sy); rh = p[2*W-1:W]; rl = p[W-1:0]; end
            2'b01: begin p = {32'b0, x} * {32'b0, y}; rh = p[2*W-1:W]; rl = p[W-1:0]; end
            2'b10: begin
                if (y == '0) begin
                    rh = x;
                    rl = (sx < 0) ? 32'd1 : 32'hFFFF_FFFF;
                end else begin
                    q = sx / sy; r = sx % sy;
                    rh = r[W-1:0]; rl = q[W-1:0];
                end
            end
            default: begin
                if (y == '0) begin rh = x; rl = 32'hFFFF_FFFF; end
                else begin rh = x % y; rl = x / y; end
            end
        endcase
    endfunction

    always @(posedge clk) begin
        logic [W-1:0] t_hi, t_lo;
        if (rst) begin
            m_left <= 0; m_done <= 1'b0; m_hi <= '0; m_lo <= '0;
        end else begin
            m_done <= 1'b0;
            if (m_left == 0) begin
                if (start) begin
                    ref_calc(op, a, b, t_hi, t_lo);
                    p_hi <= t_hi; p_lo <= t_lo; p_tag <= cur_tag;
                    m_left <= W + 1;
                end
            end else begin
                if (start) p_tag <= "R4";
                m_left <= m_left - 1;
                if (m_left == 1) begin
                    m_done <= 1'b1; m_hi <= p_hi; m_lo <= p_lo; r_tag <= p_tag;
                end
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Compare on every cycle, away from the active edge
    always @(negedge clk) begin
        string ftag, dtag;
        cyc++;
        ftag = (rst || m_left == W + 2) ? "R1" : "R2";
        dtag = rst ? "R1" : (m_done ? r_tag : "R3");
        chk(ftag, "busy", W'(busy), W'(m_left != 0));
        chk(ftag, "done", W'(done), W'(m_done));
        chk(dtag, "hi",   hi, m_hi);
        chk(dtag, "lo",   lo, m_lo);
        if (cyc >= 100000) begin
            n_bad++;
            $display("FAIL R2 watchdog: actual still running, expected finished");
            summary();
            $finish;
        end
    end

    task automatic run_op(input logic [1:0] o, input logic [W-1:0] x, y,
                          input string tag, input bit poke);
        while (busy) @(negedge clk);
        cur_tag = tag; op = o; a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0; op = ~o; a = $urandom; b = $urandom;   // R4: later inputs ignored
        if (poke) begin
            repeat (5) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;      // R4: mid-run start
            repeat (W - 6) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;      // R4: start in last busy cycle
        end
        while (!done) @(negedge clk);
    endtask

    function automatic string tag_of(input logic [1:0] o);
        case (o)
            2'b00: return "R6";
            2'b01: return "R5";
            2'b10: return "R8";
            default: return "R7";
        endcase
    endfunction

    localparam logic [W-1:0] MINV = 32'h8000_0000;
    localparam logic [W-1:0] ONES = 32'hFFFF_FFFF;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;                                   // R1 checked while in reset
        @(negedge clk);
        run_op(2'b01, 32'd3, 32'd5, "R5", 1'b0);
        run_op(2'b01, ONES, ONES, "R5", 1'b0);
        run_op(2'b00, 32'd7, -32'sd2, "R6", 1'b0);
        run_op(2'b00, MINV, MINV, "R6", 1'b0);
        run_op(2'b00, MINV, ONES, "R6", 1'b0);
        run_op(2'b11, 32'd7, 32'd2, "R7", 1'b0);
        run_op(2'b11, ONES, 32'h8000_0001, "R7", 1'b0);
        run_op(2'b11, 32'd5, ONES, "R7", 1'b0);
        run_op(2'b10, -32'sd7, 32'd2, "R8", 1'b0);
        run_op(2'b10, 32'd7, -32'sd2, "R8", 1'b0);
        run_op(2'b10, -32'sd7, -32'sd2, "R8", 1'b0);
        run_op(2'b10, MINV, ONES, "R8", 1'b0);
        run_op(2'b10, MINV, 32'd1, "R8", 1'b0);
        run_op(2'b11, 32'h1234_5678, 32'd0, "R9", 1'b0);
        run_op(2'b10, 32'd99, 32'd0, "R9", 1'b0);
        run_op(2'b10, -32'sd99, 32'd0, "R9", 1'b0);
        run_op(2'b10, MINV, 32'd0, "R9", 1'b0);
        run_op(2'b01, 32'hDEAD_BEEF, 32'h1357_9BDF, "R4", 1'b1);
        run_op(2'b10, -32'sd1000, 32'd7, "R4", 1'b1);
        for (int i = 0; i < 80; i++) begin
            logic [1:0] o;
            logic [W-1:0] x, y;
            o = 2'(i % 4);
            x = $urandom;
            y = (i % 3 == 0) ? W'($urandom % 1000) : W'($urandom);
            if (i % 7 == 0) x = MINV;
            if (i % 11 == 0) y = ONES;
            run_op(o, x, y, (y == '0 && o[1]) ? "R9" : tag_of(o), 1'b0);
        end
        repeat (6) @(negedge clk);                    // R3: hold after completion
        summary();
        $finish;
    end
endmodule